// File: doc/BRIEF.md
# Paged Ring Receive Buffer Writer

This block stores received Ethernet frames into a region of shared SRAM that is managed as a ring of 256-byte pages. Bytes arrive from the receive FIFO with valid, data, last and error qualifiers. Each byte is written through an SRAM write port that must win a grant from the shared-memory arbiter. A frame occupies consecutive pages, with wrap-around from the last page of the region back to the first. Its data starts two bytes into its first page. The two leading bytes form a header holding the frame length and status. The header is written once the frame's last byte has been stored.

Two static page bounds, fixed by parameters at reset, define the region. A write-page pointer marks where the next frame will begin, and a read-page pointer marks the oldest page software still holds. The write pointer moves only after a whole frame and its header are in memory, so software never sees part of a frame. A frame that does not fit, carries an error, or runs past the maximum length is discarded. Its pages are not committed, and a drop counter counts it. Software gives pages back by presenting a page count on the read-advance input.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, the read page and write page both equal START_PAGE, the ring reports empty and not full, the drop count is zero, and no SRAM request is raised while no byte is offered.
- R2: Data byte i of a frame is written at page offset (i+2) mod 256 of page first+floor((i+2)/256). Page numbers past END_PAGE continue from START_PAGE. All writes fall inside [START_PAGE, END_PAGE].
- R3: Offset 0 of a stored frame's first page receives length[7:0]. Offset 1 receives {3'b000, bit4 error = 0, bit3 good = 1, length[10:8]}. Both are written after the last data byte.
- R4: After the header is written, the write page advances by ceil((length+2)/256) pages with wrap, and the next-page output shows that new write page.
- R5: The ring reports full when committed pages fill every page of the region, which leaves the write page equal to the read page. It reports empty when software has returned every committed page.
- R6: A frame is discarded if its first byte meets a full ring, or if it needs a page beyond the free ones. The discard happens at the first byte that has no page. The write page stays put and the drop count rises by one.
- R7: A frame with the error flag on any byte is discarded at that byte. That byte is not written, the write page stays put and the drop count rises by one.
- R8: A frame whose byte count exceeds MAX_LEN is discarded at byte MAX_LEN+1 with the drop count raised. A frame of exactly MAX_LEN bytes (1518 by default, six pages) is stored.
- R9: While an SRAM request waits for its grant, the block holds ready low toward the FIFO and keeps the address and data unchanged.
- R10: A read advance of n pages moves the read page by n with wrap. When n exceeds the committed pages, the move is limited to the committed count and the advance-error output pulses for one cycle.
- R11: Once a frame is discarded, its remaining bytes up to and including the last are accepted without any SRAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | FIFO byte valid |
| in_data | input | 8 | FIFO byte |
| in_last | input | 1 | Byte ends the frame |
| in_err | input | 1 | Frame has a receive error |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| mem_req | output | 1 | SRAM write request |
| mem_addr | output | ADDR_W | SRAM byte address {page, offset} |
| mem_wdata | output | 8 | SRAM write byte |
| mem_gnt | input | 1 | Arbiter grant for the current request |
| rd_adv_valid | input | 1 | Software returns pages |
| rd_adv_pages | input | ADDR_W-PAGE_BITS | Number of pages returned |
| rd_page | output | ADDR_W-PAGE_BITS | Current read page |
| wr_page | output | ADDR_W-PAGE_BITS | Current write page |
| next_page | output | ADDR_W-PAGE_BITS | Page following the last stored frame |
| ring_full | output | 1 | All pages committed |
| ring_empty | output | 1 | No committed pages |
| adv_err | output | 1 | Last read advance was limited |
| drop_count | output | CNT_W | Discarded frame count |

## Verification
The bench builds the block with an eight-page region (pages 0x10 to 0x17), 256-byte pages and a 1518-byte length limit. With this setup, a single maximum-length frame takes six of the eight pages. A few frames are enough to wrap the write pointer, fill the ring, and run out of pages in mid-frame. The arbiter grant is withheld at random, which exercises request stalls. Random frame lengths up to past the limit, random error beats and random page returns are mixed with directed cases: the one-page/two-page boundary at 254/255 bytes, the full-ring reject, and over-large page returns.

// File: rtl/rxr_pkg.sv
// Shared types and header field positions for the paged receive ring.
package rxr_pkg;
    // Frame length field width in the two-byte page header.
    localparam int LEN_W = 11;

    // Writer states: taking bytes, discarding bytes, header low, header high.
    typedef enum logic [1:0] {
        ST_DATA   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_HDR_LO = 2'd2,
        ST_HDR_HI = 2'd3
    } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptrs.sv
// Read/write page pointers and committed page count for the ring.
// Assumes START_PAGE <= END_PAGE and that a commit never exceeds the
// free page count (the frame writer guarantees this).
module rxr_ring_ptrs #(
    parameter int PG_W       = 8,
    parameter int START_PAGE = 64,
    parameter int END_PAGE   = 95
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  logic [PG_W:0]   commit_pages_i,
    input  logic            adv_valid_i,
    input  logic [PG_W-1:0] adv_pages_i,
    output logic [PG_W-1:0] rd_pg_o,
    output logic [PG_W-1:0] wr_pg_o,
    output logic [PG_W:0]   free_o,
    output logic            full_o,
    output logic            empty_o,
    output logic            adv_err_o
);
    localparam int CW = PG_W + 1;
    localparam int NPAGES = END_PAGE - START_PAGE + 1;
    localparam logic [PG_W-1:0] START_P = PG_W'(START_PAGE);
    localparam logic [CW-1:0]   END_W   = CW'(END_PAGE);
    localparam logic [CW-1:0]   NPG_W   = CW'(NPAGES);

    logic [CW-1:0] used_q;
    logic [CW-1:0] adv_req;
    logic [CW-1:0] adv_eff;
    logic          adv_over;

    // Add a page count to a page index, wrapping inside the region.
    function automatic logic [PG_W-1:0] wrap_add(input logic [PG_W-1:0] p,
                                                 input logic [CW-1:0] c);
        logic [CW:0] s;
        s = {2'b00, p} + {1'b0, c};
        if (s > {1'b0, END_W}) s = s - {1'b0, NPG_W};
        return s[PG_W-1:0];
    endfunction

    // Clamp a read advance to the pages that are committed.
    always_comb begin
        adv_req  = {1'b0, adv_pages_i};
        adv_over = adv_req > used_q;
        adv_eff  = adv_over ? used_q : adv_req;
    end

    // Pointer, occupancy and advance-error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pg_o   <= START_P;
            wr_pg_o   <= START_P;
            used_q    <= '0;
            adv_err_o <= 1'b0;
        end else begin
            if (commit_i) wr_pg_o <= wrap_add(wr_pg_o, commit_pages_i);
            if (adv_valid_i) rd_pg_o <= wrap_add(rd_pg_o, adv_eff);
            used_q <= used_q + (commit_i ? commit_pages_i : '0)
                             - (adv_valid_i ? adv_eff : '0);
            adv_err_o <= adv_valid_i && adv_over;
        end
    end

    assign free_o  = NPG_W - used_q;
    assign full_o  = (used_q == NPG_W);
    assign empty_o = (used_q == '0);

    // R5
    full_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (rd_pg_o == wr_pg_o));
    // R5
    empty_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> (rd_pg_o == wr_pg_o));
    // R10
    used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= NPG_W);
endmodule

// File: rtl/rxr_frame_wr.sv
// Writes received bytes into ring pages, then the two-byte header, then
// commits the frame's pages. Discards frames that are errored, too long
// or out of pages. Assumes the FIFO holds a valid byte until accepted.
module rxr_frame_wr
    import rxr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BITS  = 8,
    parameter int START_PAGE = 64,
    parameter int END_PAGE   = 95,
    parameter int MAX_LEN    = 1518,
    parameter int CNT_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    input  logic                        in_last,
    input  logic                        in_err,
    output logic                        in_ready,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [7:0]                  mem_wdata,
    input  logic                        mem_gnt,
    input  logic [ADDR_W-PAGE_BITS-1:0] wr_pg_i,
    input  logic [ADDR_W-PAGE_BITS:0]   free_i,
    output logic                        commit_o,
    output logic [ADDR_W-PAGE_BITS:0]   commit_pages_o,
    output logic [ADDR_W-PAGE_BITS-1:0] next_pg_o,
    output logic [CNT_W-1:0]            drop_cnt_o
);
    localparam int PG_W = ADDR_W - PAGE_BITS;
    localparam int CW   = PG_W + 1;
    localparam logic [PG_W-1:0]      START_P = PG_W'(START_PAGE);
    localparam logic [PG_W-1:0]      END_P   = PG_W'(END_PAGE);
    localparam logic [PAGE_BITS-1:0] OFF_D0  = PAGE_BITS'(2);
    localparam logic [LEN_W:0]       MAX_W   = (LEN_W+1)'(MAX_LEN);

    rxr_state_e           st_q;
    logic                 busy_q;
    logic [PG_W-1:0]      cur_pg_q, first_pg_q, tail_next_q;
    logic [PAGE_BITS-1:0] cur_off_q;
    logic [CW-1:0]        fr_pages_q;
    logic [LEN_W-1:0]     fr_len_q;

    logic [PG_W-1:0]      b_pg;
    logic [PAGE_BITS-1:0] b_off;
    logic [CW-1:0]        b_cnt;
    logic [LEN_W:0]       len_n;
    logic                 drop_beat;
    logic [7:0]           hdr_hi;

    // Next page index with wrap at the region end.
    function automatic logic [PG_W-1:0] wrap_inc(input logic [PG_W-1:0] p);
        return (p == END_P) ? START_P : p + PG_W'(1);
    endfunction

    // Position, page count and length the offered byte would take.
    always_comb begin
        b_pg      = busy_q ? cur_pg_q : wr_pg_i;
        b_off     = busy_q ? cur_off_q : OFF_D0;
        b_cnt     = busy_q ? fr_pages_q : CW'(1);
        len_n     = (busy_q ? {1'b0, fr_len_q} : '0) + (LEN_W+1)'(1);
        drop_beat = in_err || (len_n > MAX_W) || (b_cnt > free_i);
        hdr_hi    = {3'b000, 1'b0, 1'b1, fr_len_q[LEN_W-1:8]};
    end

    // SRAM port, FIFO ready and commit strobe per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = {b_pg, b_off};
        mem_wdata = in_data;
        in_ready  = 1'b0;
        commit_o  = 1'b0;
        case (st_q)
            ST_DATA: begin
                if (in_valid && !drop_beat) begin
                    mem_req  = 1'b1;
                    in_ready = mem_gnt;
                end else begin
                    in_ready = 1'b1;
                end
            end
            ST_FLUSH: in_ready = 1'b1;
            ST_HDR_LO: begin
                mem_req   = 1'b1;
                mem_addr  = {first_pg_q, PAGE_BITS'(0)};
                mem_wdata = fr_len_q[7:0];
            end
            default: begin
                mem_req   = 1'b1;
                mem_addr  = {first_pg_q, PAGE_BITS'(1)};
                mem_wdata = hdr_hi;
                commit_o  = mem_gnt;
            end
        endcase
    end

    assign commit_pages_o = fr_pages_q;

    // Frame state machine, position tracking and drop counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_DATA;
            busy_q      <= 1'b0;
            cur_pg_q    <= START_P;
            first_pg_q  <= START_P;
            tail_next_q <= START_P;
            next_pg_o   <= START_P;
            cur_off_q   <= OFF_D0;
            fr_pages_q  <= '0;
            fr_len_q    <= '0;
            drop_cnt_o  <= '0;
        end else begin
            case (st_q)
                ST_DATA: begin
                    if (in_valid && in_ready) begin
                        if (drop_beat) begin
                            drop_cnt_o <= drop_cnt_o + CNT_W'(1);
                            busy_q     <= 1'b0;
                            st_q       <= in_last ? ST_DATA : ST_FLUSH;
                        end else begin
                            if (!busy_q) first_pg_q <= wr_pg_i;
                            busy_q   <= 1'b1;
                            fr_len_q <= len_n[LEN_W-1:0];
                            if (in_last) begin
                                fr_pages_q  <= b_cnt;
                                tail_next_q <= wrap_inc(b_pg);
                                st_q        <= ST_HDR_LO;
                            end else if (&b_off) begin
                                cur_pg_q   <= wrap_inc(b_pg);
                                cur_off_q  <= '0;
                                fr_pages_q <= b_cnt + CW'(1);
                            end else begin
                                cur_pg_q   <= b_pg;
                                cur_off_q  <= b_off + PAGE_BITS'(1);
                                fr_pages_q <= b_cnt;
                            end
                        end
                    end
                end
                ST_FLUSH: if (in_valid && in_last) st_q <= ST_DATA;
                ST_HDR_LO: if (mem_gnt) st_q <= ST_HDR_HI;
                default: begin
                    if (mem_gnt) begin
                        st_q      <= ST_DATA;
                        busy_q    <= 1'b0;
                        next_pg_o <= tail_next_q;
                    end
                end
            endcase
        end
    end

    // R11
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FLUSH) |-> !mem_req);
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[ADDR_W-1:PAGE_BITS] >= START_P &&
                     mem_addr[ADDR_W-1:PAGE_BITS] <= END_P));
    // R4
    next_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (wr_pg_i == next_pg_o));
endmodule

// File: rtl/rx_page_ring.sv
// Top of the paged receive ring: joins the frame writer to the pointer
// block. START_PAGE..END_PAGE give the region's page bounds.
module rx_page_ring #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BITS  = 8,
    parameter int START_PAGE = 64,
    parameter int END_PAGE   = 95,
    parameter int MAX_LEN    = 1518,
    parameter int CNT_W      = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    input  logic                        in_last,
    input  logic                        in_err,
    output logic                        in_ready,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [7:0]                  mem_wdata,
    input  logic                        mem_gnt,
    input  logic                        rd_adv_valid,
    input  logic [ADDR_W-PAGE_BITS-1:0] rd_adv_pages,
    output logic [ADDR_W-PAGE_BITS-1:0] rd_page,
    output logic [ADDR_W-PAGE_BITS-1:0] wr_page,
    output logic [ADDR_W-PAGE_BITS-1:0] next_page,
    output logic                        ring_full,
    output logic                        ring_empty,
    output logic                        adv_err,
    output logic [CNT_W-1:0]            drop_count
);
    localparam int PG_W = ADDR_W - PAGE_BITS;

    logic            commit;
    logic [PG_W:0]   commit_pages;
    logic [PG_W:0]   free_pages;

    rxr_frame_wr #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .START_PAGE(START_PAGE),
        .END_PAGE(END_PAGE), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_err(in_err), .in_ready(in_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt),
        .wr_pg_i(wr_page), .free_i(free_pages),
        .commit_o(commit), .commit_pages_o(commit_pages),
        .next_pg_o(next_page), .drop_cnt_o(drop_count)
    );

    rxr_ring_ptrs #(
        .PG_W(PG_W), .START_PAGE(START_PAGE), .END_PAGE(END_PAGE)
    ) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .commit_pages_i(commit_pages),
        .adv_valid_i(rd_adv_valid), .adv_pages_i(rd_adv_pages),
        .rd_pg_o(rd_page), .wr_pg_o(wr_page), .free_o(free_pages),
        .full_o(ring_full), .empty_o(ring_empty), .adv_err_o(adv_err)
    );
endmodule

// File: tb/rx_page_ring_tb_top.sv
// Bench: directed corner cases plus seeded random frames and page returns,
// checked against a page-count model of the ring.
module rx_page_ring_tb_top;
    localparam int SP = 16, EP = 23, NP = 8, MAXL = 1518;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, mem_req, mem_gnt = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        rd_adv_valid = 1'b0;
    logic [7:0]  rd_adv_pages = '0;
    logic [7:0]  rd_page, wr_page, next_page;
    logic        ring_full, ring_empty, adv_err;
    logic [15:0] drop_count;

    int checks = 0, errors = 0;
    int m_rd = SP, m_wr = SP, m_used = 0, m_drop = 0;
    int wr_count = 0;
    bit done = 1'b0;
    logic [7:0] mem [0:NP*256-1];
    logic [7:0] fb  [0:2047];

    always #5 clk = ~clk;

    rx_page_ring #(.ADDR_W(16), .PAGE_BITS(8), .START_PAGE(SP), .END_PAGE(EP),
                   .MAX_LEN(MAXL), .CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .rd_adv_valid(rd_adv_valid),
        .rd_adv_pages(rd_adv_pages), .rd_page(rd_page), .wr_page(wr_page),
        .next_page(next_page), .ring_full(ring_full), .ring_empty(ring_empty),
        .adv_err(adv_err), .drop_count(drop_count));

    // SRAM model: store granted writes inside the region, count them.
    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            wr_count <= wr_count + 1;
            if (int'(mem_addr) >= SP*256 && int'(mem_addr) < (EP+1)*256)
                mem[int'(mem_addr) - SP*256] <= mem_wdata;
        end
    end

    function automatic int wrapf(input int p, input int c);
        return ((p - SP + c) % NP) + SP;
    endfunction

    function automatic int midx(input int pg, input int off);
        return (pg - SP) * 256 + off;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(ring_full == (m_used == NP), req, "full flag", int'(ring_full), int'(m_used == NP));
        chk(ring_empty == (m_used == 0), req, "empty flag", int'(ring_empty), int'(m_used == 0));
    endtask

    // Offer one frame; err_at < 0 means no error beat.
    task automatic send(input int len, input int err_at, input string req);
        int need, free, exp_w, first, bad;
        bit stored;
        need  = (len + 2 + 255) / 256;
        free  = NP - m_used;
        first = m_wr;
        exp_w = len + 2;
        stored = 1'b1;
        if (need > free) begin
            stored = 1'b0;
            exp_w = (free == 0) ? 0 : free * 256 - 2;
        end
        if (len > MAXL && MAXL < exp_w) begin stored = 1'b0; exp_w = MAXL; end
        if (err_at >= 0 && err_at < len && err_at < exp_w) begin
            stored = 1'b0; exp_w = err_at;
        end
        for (int i = 0; i < len; i++) fb[i % 2048] = 8'($urandom);
        @(negedge clk);
        wr_count = 0;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = fb[i % 2048];
            in_last  = (i == len - 1);
            in_err   = (i == err_at);
            mem_gnt  = ($urandom % 4) != 0;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                mem_gnt = ($urandom % 4) != 0;
                #1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; mem_gnt = 1'b1;
        repeat (4) @(negedge clk);
        if (!stored) m_drop++;
        chk(wr_count == exp_w, req, "SRAM write count", wr_count, exp_w);
        chk(int'(drop_count) == m_drop, req, "drop count", int'(drop_count), m_drop);
        if (stored) begin
            m_wr = wrapf(m_wr, need);
            m_used += need;
            // R3 header bytes at the first page
            chk(mem[midx(first, 0)] == 8'(len), "R3", "header low",
                int'(mem[midx(first, 0)]), len & 255);
            chk(mem[midx(first, 1)] == (8'h08 | 8'(len >> 8)), "R3", "header high",
                int'(mem[midx(first, 1)]), 8 | (len >> 8));
            // R2 data placement across pages with wrap
            bad = -1;
            for (int i = 0; i < len; i++)
                if (bad < 0 && mem[midx(wrapf(first, (i + 2) / 256), (i + 2) % 256)] != fb[i])
                    bad = i;
            chk(bad < 0, "R2", "first bad data byte index", bad, -1);
            // R4 next page
            chk(int'(next_page) == m_wr, "R4", "next page", int'(next_page), m_wr);
        end
        // R4 R6 write pointer
        chk(int'(wr_page) == m_wr, req, "write page", int'(wr_page), m_wr);
        chk_flags("R5");
    endtask

    // Return n pages through the read-advance input.
    task automatic adv(input int n);
        int eff;
        bit over;
        over = n > m_used;
        eff  = over ? m_used : n;
        @(negedge clk);
        rd_adv_valid = 1'b1;
        rd_adv_pages = 8'(n);
        @(negedge clk);
        rd_adv_valid = 1'b0;
        m_rd = wrapf(m_rd, eff);
        m_used -= eff;
        chk(int'(rd_page) == m_rd, "R10", "read page", int'(rd_page), m_rd);
        chk(adv_err == over, "R10", "advance error", int'(adv_err), int'(over));
        @(negedge clk);
        chk(adv_err == 1'b0, "R10", "advance error pulse end", int'(adv_err), 0);
        chk_flags("R5");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int'(rd_page) == SP, "R1", "read page", int'(rd_page), SP);
        chk(int'(wr_page) == SP, "R1", "write page", int'(wr_page), SP);
        chk(ring_empty && !ring_full, "R1", "empty/full", int'({ring_empty, ring_full}), 2);
        chk(drop_count == 0, "R1", "drop count", int'(drop_count), 0);
        chk(!mem_req, "R1", "idle request", int'(mem_req), 0);

        send(1, -1, "R4");
        send(254, -1, "R4");       // one page
        send(255, -1, "R4");       // two pages
        send(100, 40, "R7");       // error beat mid-frame
        adv(4);                    // ring empty again
        send(MAXL + 1, -1, "R8");  // too long
        send(MAXL, -1, "R8");      // six pages, wraps
        send(600, -1, "R6");       // runs out of pages mid-frame (R11)
        send(300, -1, "R5");       // fills the ring
        send(10, -1, "R6");        // rejected while full
        adv(9);                    // over-large return, clamped
        adv(1);                    // return on empty ring
        send(20, 0, "R7");         // error on first byte

        for (int k = 0; k < 40; k++) begin
            if (($urandom % 3) == 0) adv($urandom % 5);
            else send(($urandom % 1600) + 1,
                      (($urandom % 8) == 0) ? int'($urandom % 300) : -1, "R9");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule